// File: doc/BRIEF.md
# Program Fetch Router and Multiplexed Bus Cycle Engine

This block serves the instruction-fetch port of a small CPU. For every fetch request it decides whether the code byte lives in the on-chip ROM or on an external memory, and it answers with a one-cycle response pulse carrying the byte. The decision uses two inputs. One is a strap that either permits on-chip fetching or forces everything off-chip. The other is a select that sets the on-chip ROM size to 4K, 8K or 16K bytes, or to no ROM at all.

On-chip fetches read an asynchronous ROM port and respond on the next cycle. Off-chip fetches run a fixed bus cycle that uses sixteen lines. A high-address port carries the upper address byte. A shared address/data port first drives the lower address byte while an address-latch pulse is high. It keeps driving that byte for one more cycle after the pulse drops. It then floats while an active-low program-read strobe is held for a configurable number of cycles. The returned byte is captured on the last strobe cycle. The CPU side uses a valid/ready request and a single-cycle response strobe.

Top module: `pfetch_bus`

## Requirements
- R1: While reset is held and on the first cycle after it is released, these values hold: `psen_n`=1, `ale`=0, `ad_oe`=0, `rsp_valid`=0, `req_ready`=1, `addr_hi`=8'h00 and `ad_out`=8'h00. The bus address latch therefore starts at 0000H.
- R2: With `strap_int_en`=1, a fetch is on-chip when the address is below the limit chosen by `rom_size_sel`. The encodings are 0 = 4K (below 1000H), 1 = 8K (below 2000H), 2 = 16K (below 4000H) and 3 = no ROM, which sends every address off-chip. Every other address is fetched off-chip.
- R3: With `strap_int_en`=0, every fetch is off-chip, whatever `rom_size_sel` holds.
- R4: An on-chip fetch raises `rom_rd` in its accept cycle, with `rom_addr` equal to the low ROM_AW address bits. On the next cycle it gives `rsp_valid`=1 with `rsp_data` equal to `rom_data` at accept. `psen_n` stays 1 and `ale` stays 0 throughout.
- R5: In the first cycle after an off-chip accept, `ale`=1 and `ad_oe`=1. In that cycle `ad_out` carries address bits 7:0 and `addr_hi` carries bits 15:8. `ale` is high for exactly one cycle.
- R6: In the second cycle, `ale`=0, `psen_n`=1, and `ad_out` and `addr_hi` still drive the same address with `ad_oe`=1.
- R7: For the next STROBE_CYCLES cycles, `psen_n`=0 and `ad_oe`=0, so the shared port floats.
- R8: `ad_in` is captured at the clock edge that ends the last strobe cycle. `rsp_valid`=1 with that byte follows in the next cycle, 3+STROBE_CYCLES cycles after the accept edge, and `psen_n` has returned to 1.
- R9: `req_ready` is 0 from the off-chip accept until the response cycle. Requests presented in that window are ignored: they start no cycle and produce no response.
- R10: `psen_n`=0 and `ad_oe`=1 never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_int_en | input | 1 | 1 permits on-chip fetches, 0 forces all fetches off-chip |
| rom_size_sel | input | 2 | On-chip ROM size: 0=4K, 1=8K, 2=16K, 3=none |
| req_valid | input | 1 | Fetch request valid |
| req_addr | input | 16 | Fetch address |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle pulse with the fetched byte |
| rsp_data | output | 8 | Fetched code byte |
| rom_rd | output | 1 | On-chip ROM read enable |
| rom_addr | output | ROM_AW | On-chip ROM address |
| rom_data | input | 8 | On-chip ROM data (asynchronous read) |
| ad_out | output | 8 | Shared port output: low address byte |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input: returned code byte |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch pulse |
| psen_n | output | 1 | Active-low program read strobe |

## Verification
The bench builds the block with STROBE_CYCLES=3 and the default ROM_AW=14. A strobe longer than one cycle makes the width counter step through several values, and it moves the capture edge away from the strobe's first edge, so a capture taken too early shows up as a wrong byte. ROM_AW=14 matches the 16K limit, so the widest on-chip range is reachable, and the directed cases test the addresses on both sides of every limit.

// File: rtl/pfetch_pkg.sv
package pfetch_pkg;

    localparam int FA_W = 16;
    localparam int FB_W = 8;

    typedef enum logic [1:0] {
        ROM_4K   = 2'd0,
        ROM_8K   = 2'd1,
        ROM_16K  = 2'd2,
        ROM_NONE = 2'd3
    } rom_size_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ALE,
        PH_HOLD,
        PH_STRB
    } phase_e;

    typedef struct packed {
        logic [FB_W-1:0] hi;
        logic [FB_W-1:0] lo;
    } faddr_t;

    // True when the address lies inside the on-chip window of the selected size.
    function automatic logic below_limit(input faddr_t a, input rom_size_e sz);
        logic r;
        case (sz)
            ROM_4K:  r = (a.hi[7:4] == 4'h0);
            ROM_8K:  r = (a.hi[7:5] == 3'h0);
            ROM_16K: r = (a.hi[7:6] == 2'h0);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pfetch_route.sv
module pfetch_route
    import pfetch_pkg::*;
#(
    parameter int ROM_AW = 14
) (
    input  faddr_t            addr,
    input  logic [1:0]        size_sel,
    input  logic              strap,
    output logic              on_chip,
    output logic [ROM_AW-1:0] rom_addr
);
    always_comb begin
        on_chip  = strap && below_limit(addr, rom_size_e'(size_sel));
        rom_addr = addr[ROM_AW-1:0];
    end
endmodule

// File: rtl/pfetch_seq.sv
module pfetch_seq
    import pfetch_pkg::*;
#(
    parameter int STROBE_CYCLES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  faddr_t          addr,
    input  logic [FB_W-1:0] ad_in,
    output logic [FB_W-1:0] ad_out,
    output logic            ad_oe,
    output logic [FB_W-1:0] addr_hi,
    output logic            ale,
    output logic            psen_n,
    output logic            busy,
    output logic            cap_valid,
    output logic [FB_W-1:0] cap_data
);
    localparam int CW = $clog2(STROBE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STROBE_CYCLES - 1);

    phase_e        phase;
    logic [CW-1:0] cnt;
    faddr_t        lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            lat       <= '0;
            cap_valid <= 1'b0;
            cap_data  <= '0;
        end else begin
            cap_valid <= 1'b0;
            case (phase)
                PH_IDLE: if (start) begin
                    lat   <= addr;
                    phase <= PH_ALE;
                end
                PH_ALE:  phase <= PH_HOLD;
                PH_HOLD: begin
                    cnt   <= '0;
                    phase <= PH_STRB;
                end
                PH_STRB: begin
                    if (cnt == LAST) begin
                        cap_data  <= ad_in;
                        cap_valid <= 1'b1;
                        phase     <= PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ad_out  = lat.lo;
        addr_hi = lat.hi;
        ale     = (phase == PH_ALE);
        ad_oe   = (phase == PH_ALE) || (phase == PH_HOLD);
        psen_n  = (phase != PH_STRB);
        busy    = (phase != PH_IDLE);
    end

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);  // R5
    AST_ALE_TO_HOLD: assert property (@(posedge clk) disable iff (rst)
        ale |=> (ad_oe && psen_n)); // R6
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (ad_oe && !ale) |-> ($stable(ad_out) && $stable(addr_hi))); // R6
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        !(ad_oe && !psen_n)); // R10
    AST_HOLD_TO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (ad_oe && !ale) |=> !psen_n); // R7
endmodule

// File: rtl/pfetch_bus.sv
module pfetch_bus
    import pfetch_pkg::*;
#(
    parameter int ROM_AW        = 14,
    parameter int STROBE_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_int_en,
    input  logic [1:0]        rom_size_sel,
    input  logic              req_valid,
    input  logic [15:0]       req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    output logic              rom_rd,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [7:0]        rom_data,
    output logic [7:0]        ad_out,
    output logic              ad_oe,
    input  logic [7:0]        ad_in,
    output logic [7:0]        addr_hi,
    output logic              ale,
    output logic              psen_n
);
    faddr_t     fa;
    logic       on_chip;
    logic       accept;
    logic       busy;
    logic       cap_valid;
    logic [7:0] cap_data;
    logic       int_valid_q;
    logic [7:0] int_data_q;

    assign fa = faddr_t'(req_addr);

    pfetch_route #(.ROM_AW(ROM_AW)) u_route (
        .addr     (fa),
        .size_sel (rom_size_sel),
        .strap    (strap_int_en),
        .on_chip  (on_chip),
        .rom_addr (rom_addr)
    );

    pfetch_seq #(.STROBE_CYCLES(STROBE_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (accept && !on_chip),
        .addr      (fa),
        .ad_in     (ad_in),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .addr_hi   (addr_hi),
        .ale       (ale),
        .psen_n    (psen_n),
        .busy      (busy),
        .cap_valid (cap_valid),
        .cap_data  (cap_data)
    );

    always_comb begin
        req_ready = !busy;
        accept    = req_valid && req_ready;
        rom_rd    = accept && on_chip;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_valid_q <= 1'b0;
            int_data_q  <= '0;
        end else begin
            int_valid_q <= rom_rd;
            if (rom_rd) int_data_q <= rom_data;
        end
    end

    always_comb begin
        rsp_valid = int_valid_q || cap_valid;
        rsp_data  = int_valid_q ? int_data_q : cap_data;
    end

    AST_INT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        rom_rd |=> (psen_n && !ale)); // R4
    AST_INT_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        rom_rd |=> rsp_valid); // R4
    AST_STRAP_LOW_EXT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !strap_int_en) |=> ale); // R3
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!psen_n || ale) |-> !req_ready); // R9
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !$past(rom_rd)) |=> !rsp_valid); // R8
endmodule

// File: tb/sim_pfetch_bus.sv
module sim_pfetch_bus;
    localparam int ROM_AW = 14;
    localparam int SC     = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              strap_int_en = 1'b1;
    logic [1:0]        rom_size_sel = 2'd0;
    logic              req_valid = 1'b0;
    logic [15:0]       req_addr = '0;
    logic              req_ready;
    logic              rsp_valid;
    logic [7:0]        rsp_data;
    logic              rom_rd;
    logic [ROM_AW-1:0] rom_addr;
    logic [7:0]        rom_data;
    logic [7:0]        ad_out;
    logic              ad_oe;
    logic [7:0]        ad_in;
    logic [7:0]        addr_hi;
    logic              ale;
    logic              psen_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] ext_lat = '0;

    always #5 clk = ~clk;

    function automatic logic [7:0] rom_f(input logic [ROM_AW-1:0] a);
        return a[7:0] ^ {2'b00, a[13:8]} ^ 8'hC3;
    endfunction

    function automatic logic [7:0] ext_f(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic bit exp_int(input logic [15:0] a, input logic s, input logic [1:0] sz);
        logic [16:0] lim;
        case (sz)
            2'd0: lim = 17'h01000;
            2'd1: lim = 17'h02000;
            2'd2: lim = 17'h04000;
            default: lim = 17'h0;
        endcase
        return s && ({1'b0, a} < lim);
    endfunction

    assign rom_data = rom_f(rom_addr);
    assign ad_in    = ext_f(ext_lat);

    // External address latch model
    always @(negedge clk) if (ale) ext_lat <= {addr_hi, ad_out};

    pfetch_bus #(.ROM_AW(ROM_AW), .STROBE_CYCLES(SC)) u0 (
        .clk(clk), .rst(rst), .strap_int_en(strap_int_en), .rom_size_sel(rom_size_sel),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rom_rd(rom_rd), .rom_addr(rom_addr),
        .rom_data(rom_data), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .addr_hi(addr_hi), .ale(ale), .psen_n(psen_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic fetch(input logic [15:0] a, input logic s, input logic [1:0] sz, input bit poke);
        bit in_rom;
        in_rom = exp_int(a, s, sz);
        strap_int_en = s;
        rom_size_sel = sz;
        req_addr = a;
        req_valid = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R9 ready when idle", {31'b0, req_ready}, 1);
        chk(rom_rd == in_rom, s ? "R2 route" : "R3 strap low route", {31'b0, rom_rd}, {31'b0, in_rom});
        if (in_rom)
            chk(rom_addr == a[ROM_AW-1:0], "R4 rom_addr", {18'b0, rom_addr}, {18'b0, a[ROM_AW-1:0]});
        @(negedge clk);
        req_valid = 1'b0;
        if (in_rom) begin
            chk(rsp_valid && rsp_data == rom_f(a[ROM_AW-1:0]), "R4 on-chip data",
                {23'b0, rsp_valid, rsp_data}, {24'b1, rom_f(a[ROM_AW-1:0])});
            chk(psen_n && !ale, "R4 bus quiet", {30'b0, psen_n, ale}, 32'h2);
        end else begin
            chk(ale && ad_oe && ad_out == a[7:0] && addr_hi == a[15:8], "R5 address phase",
                {14'b0, ale, ad_oe, addr_hi, ad_out}, {14'b0, 2'b11, a});
            chk(!rsp_valid && !req_ready, "R9 busy no rsp", {30'b0, rsp_valid, req_ready}, 0);
            if (poke) begin
                req_valid = 1'b1;
                req_addr  = ~a;
            end
            @(negedge clk);
            chk(!ale && ad_oe && psen_n && ad_out == a[7:0] && addr_hi == a[15:8], "R6 hold phase",
                {13'b0, ale, ad_oe, psen_n, addr_hi, ad_out}, {13'b0, 3'b011, a});
            for (int i = 0; i < SC; i++) begin
                @(negedge clk);
                chk(!psen_n && !ad_oe && !ale, "R7 strobe phase", {29'b0, psen_n, ad_oe, ale}, 0);
                chk(!req_ready && !rsp_valid, "R9 ignored during strobe", {30'b0, req_ready, rsp_valid}, 0);
                if (i == SC - 1) req_valid = 1'b0;
            end
            @(negedge clk);
            chk(rsp_valid && rsp_data == ext_f(a) && psen_n, "R8 captured byte",
                {22'b0, rsp_valid, psen_n, rsp_data}, {22'b0, 2'b11, ext_f(a)});
        end
        @(negedge clk);
        chk(!rsp_valid && !ale && psen_n, "R9 no spurious cycle", {29'b0, rsp_valid, ale, psen_n}, 1);
    endtask

    initial begin
        logic [15:0] edges [8];
        edges = '{16'h0000, 16'h0FFF, 16'h1000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000, 16'hFFFF};
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(psen_n && !ale && !ad_oe && !rsp_valid && req_ready && addr_hi == 0 && ad_out == 0,
            "R1 in reset", {27'b0, psen_n, ale, ad_oe, rsp_valid, req_ready}, 32'h11);
        rst = 1'b0;
        @(negedge clk);
        chk(psen_n && !ale && !ad_oe && !rsp_valid && req_ready && addr_hi == 0 && ad_out == 0,
            "R1 after reset", {11'b0, psen_n, ale, ad_oe, rsp_valid, req_ready, addr_hi, ad_out}, 32'h110000);
        // Directed boundaries, every size and both strap values
        for (int s = 0; s < 2; s++)
            for (int z = 0; z < 4; z++)
                for (int e = 0; e < 8; e++)
                    fetch(edges[e], s[0], z[1:0], (e % 2) == 1);
        // Random mix
        for (int n = 0; n < 400; n++)
            fetch($urandom() & 16'hFFFF, ($urandom() % 4) != 0, $urandom() % 4, ($urandom() % 2) == 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule